// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one byte into an asynchronous serial frame on a single output line. A frame is a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The bit period comes from a cycles-per-bit input, so the block runs at any rate its clock can divide down to.

A producer offers a byte with `in_valid`. The byte is taken on a clock edge where `in_ready` is high. `in_ready` then stays low for the whole frame. The data length, parity mode, stop count, inversion and bit period are captured with the byte, so software can reprogram them at any time without corrupting a frame that is already on the line. With inversion on, every line level is complemented, the idle level included. This suits links that run through an inverting level shifter. A one-cycle `done` pulse marks the moment the line returns to idle.

Top module: `uart_frame_tx`

## Requirements
- R1: While no frame is in progress, including after reset, `tx_line` holds the idle level, which is the complement of `cfg_inv`. `in_ready` is 1 and `done` is 0 out of reset.
- R2: A frame is sent in this order: start bit (0), data bits least significant first, the parity bit if enabled, then the stop bits (1). The start bit appears on `tx_line` in the cycle after the accepting edge.
- R3: `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Codes 4 to 7 select 8. Unused upper data bits are not sent.
- R4: `cfg_par` code 0 means no parity, 1 even, 2 odd, 3 mark (always 1) and 4 space (always 0). Codes 5 to 7 mean no parity. Even parity is the XOR of the sent data bits, and odd parity is its complement.
- R5: `cfg_stop` code 1 selects two stop bits. Codes 0, 2 and 3 select one.
- R6: When `cfg_inv` is 1, every bit of the frame is complemented on `tx_line`.
- R7: Every frame bit is held for exactly `cfg_bit_ticks` clock cycles. A value of 0 is treated as 1.
- R8: A byte is accepted on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the frame ends. `in_valid` and `in_data` have no effect while a frame is in progress.
- R9: `done` is high for exactly one cycle: the first cycle after the last stop bit period, when `tx_line` is back at the idle level. `in_ready` is 1 in that same cycle.
- R10: All configuration inputs are captured at acceptance. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bit_ticks | input | TICK_W | Clock cycles per bit (0 acts as 1) |
| cfg_len | input | 3 | Data length code |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop bit count code |
| cfg_inv | input | 1 | Invert the line, idle level included |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block idle, can accept a byte |
| tx_line | output | 1 | Serial output line |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach is a configuration change or a new offered byte that lands in the middle of a frame. The bench does this on purpose. On many random frames it randomises every configuration input and raises `in_valid` with fresh data right after acceptance. It then restores the captured settings only in the last bit cycle, and compares each cycle of the line against the frame computed from the settings taken at acceptance. Directed frames cover the out-of-range codes, a bit period of zero, and idle-level checks under both polarities.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] cfg_bit_ticks,
  input  logic [2:0]        cfg_len,
  input  logic [2:0]        cfg_par,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_inv,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              tx_line,
  output logic              done
);
  localparam int FRAME_W = 12;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic              busy, line_q, done_q, inv_q;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]  left;
  logic [TICK_W-1:0] tick, period_q, period;

  logic [3:0]         data_n;
  logic [7:0]         dmask, dm;
  logic               par_en, par_bit, two_stop;
  logic [FRAME_W-1:0] frm;
  logic [CNT_W-1:0]   total;

  assign in_ready = !busy;
  assign tx_line  = line_q;
  assign done     = done_q;
  assign period   = (cfg_bit_ticks == '0) ? TICK_W'(1) : cfg_bit_ticks;

  assign data_n   = cfg_len[2] ? 4'd8 : 4'({2'b00, cfg_len[1:0]} + 4'd5);
  assign dmask    = 8'hFF >> (4'd8 - data_n);
  assign dm       = in_data & dmask;
  assign two_stop = (cfg_stop == 2'd1);

  always_comb begin
    par_en  = 1'b1;
    par_bit = 1'b0;
    case (cfg_par)
      3'd1:    par_bit = ^dm;
      3'd2:    par_bit = ~^dm;
      3'd3:    par_bit = 1'b1;
      3'd4:    par_bit = 1'b0;
      default: par_en  = 1'b0;
    endcase
  end

  always_comb begin
    frm = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(data_n)) frm[1+i] = dm[i];
    if (par_en) frm[1 + int'(data_n)] = par_bit;
    total = CNT_W'(4'd1 + data_n + {3'd0, par_en} + (two_stop ? 4'd2 : 4'd1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      line_q   <= ~cfg_inv;
      done_q   <= 1'b0;
      inv_q    <= 1'b0;
      sh       <= '0;
      left     <= '0;
      tick     <= '0;
      period_q <= TICK_W'(1);
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          busy     <= 1'b1;
          inv_q    <= cfg_inv;
          line_q   <= frm[0] ^ cfg_inv;
          sh       <= frm >> 1;
          left     <= total - CNT_W'(1);
          period_q <= period;
          tick     <= period - TICK_W'(1);
        end else begin
          line_q <= ~cfg_inv;
        end
      end else if (tick != '0) begin
        tick <= tick - TICK_W'(1);
      end else if (left == '0) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
        line_q <= ~inv_q;
      end else begin
        line_q <= sh[0] ^ inv_q;
        sh     <= sh >> 1;
        left   <= left - CNT_W'(1);
        tick   <= period_q - TICK_W'(1);
      end
    end
  end
endmodule

module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_inv,
  input logic in_valid,
  input logic in_ready,
  input logic tx_line,
  input logic done
);
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && $past(in_ready) && !done) |-> (tx_line == !$past(cfg_inv)));
  a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tx_line == $past(cfg_inv)));
  a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (in_ready && !$past(in_ready)));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> done);
endmodule

bind uart_frame_tx uart_frame_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_inv(cfg_inv), .in_valid(in_valid),
  .in_ready(in_ready), .tx_line(tx_line), .done(done)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_bit_ticks = 16'd1;
  logic [2:0]  cfg_len = 3'd3;
  logic [2:0]  cfg_par = 3'd0;
  logic [1:0]  cfg_stop = 2'd0;
  logic        cfg_inv = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, tx_line, done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_frame_tx #(.TICK_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bit_ticks(cfg_bit_ticks), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_stop(cfg_stop), .cfg_inv(cfg_inv),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_line(tx_line), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void build(input logic [7:0] d, input logic [2:0] l,
                                input logic [2:0] p, input logic [1:0] s,
                                output logic [11:0] v, output int nb);
    int nd, pos;
    logic x;
    nd = (l <= 3) ? int'(l) + 5 : 8;
    v = '1;
    v[0] = 1'b0;
    x = 1'b0;
    for (int i = 0; i < nd; i++) begin
      v[1+i] = d[i];
      x = x ^ d[i];
    end
    pos = 1 + nd;
    case (p)
      3'd1: begin v[pos] = x;    pos++; end
      3'd2: begin v[pos] = ~x;   pos++; end
      3'd3: begin v[pos] = 1'b1; pos++; end
      3'd4: begin v[pos] = 1'b0; pos++; end
      default: ;
    endcase
    nb = pos + ((s == 2'd1) ? 2 : 1);
  endfunction

  task automatic frame(input logic [7:0] d, input logic [2:0] l, input logic [2:0] p,
                       input logic [1:0] s, input logic inv, input logic [15:0] tk,
                       input bit scramble, input string tag);
    logic [11:0] v;
    int nb, n, len;
    build(d, l, p, s, v, nb);
    n = (tk == 0) ? 1 : int'(tk);
    len = nb * n;
    @(negedge clk);
    chk(in_ready === 1'b1, "R8 ready before offer", in_ready, 1);
    cfg_bit_ticks = tk; cfg_len = l; cfg_par = p; cfg_stop = s; cfg_inv = inv;
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    if (scramble) begin
      in_data = 8'($urandom);
      cfg_bit_ticks = 16'($urandom_range(0, 7)); cfg_len = 3'($urandom);
      cfg_par = 3'($urandom); cfg_stop = 2'($urandom); cfg_inv = 1'($urandom);
    end else begin
      in_valid = 1'b0;
    end
    for (int j = 0; j < len; j++) begin
      if (j == len - 1) begin
        in_valid = 1'b0;
        cfg_bit_ticks = tk; cfg_len = l; cfg_par = p; cfg_stop = s; cfg_inv = inv;
      end
      chk(tx_line === (v[j / n] ^ inv), {tag, " line bit"}, tx_line, v[j / n] ^ inv);
      chk(in_ready === 1'b0 && done === 1'b0, "R8 busy flags", {in_ready, done}, 0);
      @(negedge clk);
    end
    chk(done === 1'b1 && in_ready === 1'b1, "R9 done at frame end", {done, in_ready}, 3);
    chk(tx_line === ~inv, "R9 idle at done", tx_line, ~inv);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", done, 0);
    chk(tx_line === ~inv && in_ready === 1'b1, "R1 idle after frame", {tx_line, in_ready}, {~inv, 1'b1});
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(tx_line === 1'b1 && in_ready === 1'b1 && done === 1'b0, "R1 reset state",
        {tx_line, in_ready, done}, 3'b110);
    cfg_inv = 1'b1;
    @(negedge clk);
    chk(tx_line === 1'b0, "R6 inverted idle in reset", tx_line, 0);
    cfg_inv = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_line === 1'b1 && in_ready === 1'b1, "R1 idle after reset", tx_line, 1);

    frame(8'hA5, 3'd3, 3'd0, 2'd0, 1'b0, 16'd3, 0, "R2 8N1");
    frame(8'h3F, 3'd0, 3'd1, 2'd0, 1'b0, 16'd2, 0, "R3 R4 5 bits even");
    frame(8'h81, 3'd1, 3'd2, 2'd1, 1'b0, 16'd2, 0, "R4 R5 odd two stop");
    frame(8'h00, 3'd2, 3'd3, 2'd0, 1'b0, 16'd1, 0, "R4 mark");
    frame(8'hFF, 3'd3, 3'd4, 2'd1, 1'b0, 16'd1, 0, "R4 space");
    frame(8'h5A, 3'd6, 3'd7, 2'd3, 1'b0, 16'd2, 0, "R3 R4 R5 fallback codes");
    frame(8'hC3, 3'd3, 3'd1, 2'd1, 1'b1, 16'd4, 0, "R6 inverted frame");
    frame(8'h96, 3'd3, 3'd0, 2'd0, 1'b0, 16'd0, 0, "R7 zero ticks");
    frame(8'h69, 3'd3, 3'd2, 2'd2, 1'b0, 16'd5, 1, "R10 R8 mid-frame change");

    for (int k = 0; k < 300; k++) begin
      frame(8'($urandom), 3'($urandom), 3'($urandom), 2'($urandom), 1'($urandom),
            16'($urandom_range(0, 6)), 1'($urandom), "R7 R10 random");
    end

    cfg_inv = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_line === 1'b0 && in_ready === 1'b1, "R6 idle follows inversion", tx_line, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule